// File: doc/BRIEF.md
# Double-Buffered Readout Busy Controller

This block sets the dead time of a front-end readout that has two local event buffers. A gate accepted from the trigger system claims the buffer that is next in the rotation. The block then holds busy while the front end samples the event and reads it into that buffer. When the front end signals readout-done, the buffer is queued for transfer to the host. The host link is asked to send the queued buffers one at a time. The next gate may then fill the other buffer, so the transfer of one event overlaps the readout of the next.

Busy has two sources. It is high while a readout is in progress. It is also high while the buffer that would take the next event has not yet been emptied by the host. A gate that arrives while busy is high is dropped, and the block counts it in a saturating counter. The readout and transfer datapaths are outside this block. It only tracks who owns each buffer, the order of events, and the busy line.

Top module: `readout_busy_ctrl`

## Requirements
- R1: After a gate is accepted (gate high while busy is low), busy is high from the next cycle. It stays high through the cycle in which readout-done is sampled.
- R2: Busy is high in every cycle in which the buffer selected for the next event is still queued for the host or being sent to it.
- R3: Events fill the buffers in a fixed rotation starting at index 0 (0, 1, 0, 1, ...). `rd_sel` shows the index of the buffer being filled, or of the one to be filled next. It advances in the cycle after each readout-done.
- R4: When the host link is idle, `xfer_req` rises with `xfer_sel` equal to the filled buffer. This happens two cycles after readout-done is sampled. A gate is accepted while that transfer is still running.
- R5: Buffers are offered to the host in the order they were filled. A buffer filled while another transfer is running waits. `xfer_req` is low in the cycle after `xfer_done` and rises again in the cycle after that for the waiting buffer.
- R6: A buffer becomes free only when `xfer_done` is sampled while `xfer_req` is high. `xfer_done` while `xfer_req` is low has no effect. `rdout_done` while no readout is running also has no effect.
- R7: A gate sampled while busy is high starts no readout. It adds one to `rej_count`, and the count saturates at its all-ones value.
- R8: Busy falls in the cycle after readout-done if the next buffer in the rotation is free. Otherwise it falls in the cycle after that buffer's `xfer_done`, and never at any other time.
- R9: After reset, busy, `xfer_req`, `rd_sel`, `xfer_sel` and `rej_count` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gate | input | 1 | Trigger gate, sampled each cycle |
| rdout_done | input | 1 | Front end finished reading the current event into its buffer |
| xfer_done | input | 1 | Host link finished sending the offered buffer |
| busy | output | 1 | Dead-time signal to the trigger system |
| rd_sel | output | IW | Buffer being filled or to be filled next |
| xfer_req | output | 1 | A filled buffer is offered to the host link |
| xfer_sel | output | IW | Index of the offered buffer |
| rej_count | output | REJ_W | Saturating count of gates dropped while busy |

## Verification
The assertions assume the front end raises `rdout_done` only for a readout it was given. They also assume the host raises `xfer_done` only while a transfer is offered. Stray pulses are masked inside the block, so any such pulses that do reach a buffer slot would be flagged. The assertions also assume that gates are single-cycle samples and have no edges of their own. The directed tasks drive every pulse for exactly one cycle, just after a clock edge. Stray done pulses are applied only in the scenario that checks they are ignored. Held gates are used only to exercise the saturation of the rejection counter.

// File: rtl/rb_pkg.sv
package rb_pkg;

  typedef enum logic [1:0] {
    SLOT_FREE = 2'd0,
    SLOT_FILL = 2'd1,
    SLOT_FULL = 2'd2,
    SLOT_SEND = 2'd3
  } slot_st_t;

  // next index in a ring of n entries
  function automatic logic [31:0] ring_next(input logic [31:0] idx, input int unsigned n);
    return (idx + 32'd1 >= n) ? 32'd0 : idx + 32'd1;
  endfunction

endpackage

// File: rtl/rb_slot.sv
module rb_slot
  import rb_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     claim,
  input  logic     fill_end,
  input  logic     send_start,
  input  logic     send_end,
  output slot_st_t st
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= SLOT_FREE;
    end else begin
      unique case (st)
        SLOT_FREE: if (claim)      st <= SLOT_FILL;
        SLOT_FILL: if (fill_end)   st <= SLOT_FULL;
        SLOT_FULL: if (send_start) st <= SLOT_SEND;
        SLOT_SEND: if (send_end)   st <= SLOT_FREE;
        default:                   st <= SLOT_FREE;
      endcase
    end
  end

  AST_CLAIM_ONLY_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    claim |-> st == SLOT_FREE); // R2

  AST_RELEASE_ONLY_SENDING: assert property (@(posedge clk) disable iff (!rst_n)
    send_end |-> st == SLOT_SEND); // R6

  AST_HELD_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (st != SLOT_FREE && !send_end) |=> st != SLOT_FREE); // R6

endmodule

// File: rtl/rb_rej_cnt.sv
module rb_rej_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] cnt
);

  localparam logic [W-1:0] CNT_MAX = '1;

  function automatic logic [W-1:0] sat_add1(input logic [W-1:0] v);
    return (v == CNT_MAX) ? v : v + W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt <= '0;
    else if (inc) cnt <= sat_add1(cnt);
  end

  AST_REJ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && cnt != CNT_MAX) |=> cnt == $past(cnt) + W'(1)); // R7

  AST_REJ_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && cnt == CNT_MAX) |=> cnt == CNT_MAX); // R7

  AST_REJ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !inc |=> $stable(cnt)); // R7

endmodule

// File: rtl/readout_busy_ctrl.sv
module readout_busy_ctrl
  import rb_pkg::*;
#(
  parameter int NBUF  = 2,
  parameter int REJ_W = 16,
  localparam int IW   = (NBUF > 1) ? $clog2(NBUF) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gate,
  input  logic             rdout_done,
  input  logic             xfer_done,
  output logic             busy,
  output logic [IW-1:0]    rd_sel,
  output logic             xfer_req,
  output logic [IW-1:0]    xfer_sel,
  output logic [REJ_W-1:0] rej_count
);

  logic [IW-1:0] fill_ptr;
  logic [IW-1:0] send_ptr;
  logic          sending;
  slot_st_t      slot_st [NBUF];

  // named internal events
  logic accept_ev;
  logic reject_ev;
  logic reading;
  logic rd_end_ev;
  logic head_full;
  logic tx_start_ev;
  logic tx_end_ev;

  assign reading     = (slot_st[fill_ptr] == SLOT_FILL);
  assign busy        = (slot_st[fill_ptr] != SLOT_FREE);
  assign accept_ev   = gate & ~busy;
  assign reject_ev   = gate & busy;
  assign rd_end_ev   = rdout_done & reading;
  assign head_full   = (slot_st[send_ptr] == SLOT_FULL);
  assign tx_start_ev = ~sending & head_full;
  assign tx_end_ev   = xfer_done & sending;

  genvar g;
  generate
    for (g = 0; g < NBUF; g++) begin : g_slot
      logic at_fill;
      logic at_send;
      assign at_fill = (fill_ptr == IW'(g));
      assign at_send = (send_ptr == IW'(g));
      rb_slot u_slot (
        .clk        (clk),
        .rst_n      (rst_n),
        .claim      (accept_ev & at_fill),
        .fill_end   (rd_end_ev & at_fill),
        .send_start (tx_start_ev & at_send),
        .send_end   (tx_end_ev & at_send),
        .st         (slot_st[g])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_ptr <= '0;
      send_ptr <= '0;
      sending  <= 1'b0;
    end else begin
      if (rd_end_ev)
        fill_ptr <= IW'(ring_next(32'(fill_ptr), NBUF));
      if (tx_end_ev) begin
        send_ptr <= IW'(ring_next(32'(send_ptr), NBUF));
        sending  <= 1'b0;
      end else if (tx_start_ev) begin
        sending  <= 1'b1;
      end
    end
  end

  rb_rej_cnt #(.W(REJ_W)) u_rej (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (reject_ev),
    .cnt   (rej_count)
  );

  assign rd_sel   = fill_ptr;
  assign xfer_req = sending;
  assign xfer_sel = send_ptr;

  AST_GATE_MAKES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    accept_ev |=> busy); // R1

  AST_ROTATE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    rd_end_ev |=> rd_sel == IW'(ring_next(32'($past(rd_sel)), NBUF))); // R3

  AST_GAP_AFTER_SEND: assert property (@(posedge clk) disable iff (!rst_n)
    tx_end_ev |=> !xfer_req); // R5

  AST_BUSY_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(rd_end_ev) || $past(tx_end_ev))); // R8

  AST_REJECT_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (reject_ev && !rd_end_ev) |=> rd_sel == $past(rd_sel)); // R7

endmodule

// File: tb/test_readout_busy_ctrl.sv
`timescale 1ns/1ps
module test_readout_busy_ctrl;

  localparam int NBUF  = 2;
  localparam int REJ_W = 3;
  localparam int IW    = 1;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             gate, rdout_done, xfer_done;
  logic             busy, xfer_req;
  logic [IW-1:0]    rd_sel, xfer_sel;
  logic [REJ_W-1:0] rej_count;

  int total = 0;
  int bad   = 0;
  bit fin   = 1'b0;

  always #2 clk = ~clk;

  readout_busy_ctrl #(.NBUF(NBUF), .REJ_W(REJ_W)) i_readout_busy_ctrl (
    .clk(clk), .rst_n(rst_n), .gate(gate), .rdout_done(rdout_done),
    .xfer_done(xfer_done), .busy(busy), .rd_sel(rd_sel),
    .xfer_req(xfer_req), .xfer_sel(xfer_sel), .rej_count(rej_count)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input int act, input int exp, input string req, input string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic pulse_gate();
    gate = 1'b1; step(); gate = 1'b0;
  endtask
  task automatic pulse_rd();
    rdout_done = 1'b1; step(); rdout_done = 1'b0;
  endtask
  task automatic pulse_tx();
    xfer_done = 1'b1; step(); xfer_done = 1'b0;
  endtask

  task automatic t_reset();
    chk(busy, 0, "R9", "busy");
    chk(xfer_req, 0, "R9", "xfer_req");
    chk(rd_sel, 0, "R9", "rd_sel");
    chk(xfer_sel, 0, "R9", "xfer_sel");
    chk(rej_count, 0, "R9", "rej_count");
  endtask

  task automatic t_single();
    pulse_gate();
    chk(busy, 1, "R1", "busy after gate");
    chk(rd_sel, 0, "R3", "first buffer");
    step(); step();
    chk(busy, 1, "R1", "busy during readout");
    pulse_rd();
    chk(busy, 0, "R8", "busy after readout, other free");
    chk(rd_sel, 1, "R3", "rotation to 1");
    chk(xfer_req, 0, "R4", "req not yet");
    step();
    chk(xfer_req, 1, "R4", "req raised");
    chk(xfer_sel, 0, "R4", "req buffer");
    pulse_tx();
    chk(xfer_req, 0, "R6", "req after done");
    step();
    chk(xfer_req, 0, "R6", "nothing queued");
  endtask

  task automatic t_overlap();
    pulse_gate();
    chk(rd_sel, 1, "R3", "fill buffer 1");
    pulse_rd();
    chk(busy, 0, "R8", "busy drop");
    chk(rd_sel, 0, "R3", "rotation back to 0");
    step();
    chk(xfer_req, 1, "R4", "send buffer 1");
    chk(xfer_sel, 1, "R4", "send sel 1");
    pulse_gate();
    chk(busy, 1, "R4", "gate accepted during transfer");
    chk(rd_sel, 0, "R4", "overlap fills 0");
    chk(xfer_req, 1, "R4", "transfer continues");
    pulse_rd();
    chk(busy, 1, "R2", "next buffer still sending");
    chk(rd_sel, 1, "R3", "rotation to 1");
    pulse_gate();
    chk(rej_count, 1, "R7", "reject counted");
    chk(busy, 1, "R7", "reject keeps busy");
    chk(rd_sel, 1, "R7", "reject no fill");
    step(); step();
    chk(busy, 1, "R8", "busy held until done");
    chk(xfer_sel, 1, "R5", "first filled still sent");
    pulse_tx();
    chk(busy, 0, "R8", "busy falls after done");
    chk(xfer_req, 0, "R5", "gap cycle");
    step();
    chk(xfer_req, 1, "R5", "second offered");
    chk(xfer_sel, 0, "R5", "fill order");
    pulse_tx();
    chk(xfer_req, 0, "R5", "queue empty");
    step();
  endtask

  task automatic t_stray();
    pulse_tx();
    chk(xfer_req, 0, "R6", "stray xfer_done");
    chk(busy, 0, "R6", "stray xfer_done busy");
    pulse_rd();
    chk(busy, 0, "R6", "stray rdout_done busy");
    chk(rd_sel, 1, "R6", "stray rdout_done sel");
    step();
    chk(xfer_req, 0, "R6", "stray rdout_done no req");
    pulse_gate();
    chk(rd_sel, 1, "R6", "fill unchanged");
    pulse_rd();
    step();
    chk(xfer_sel, 1, "R5", "send order kept");
    pulse_tx();
  endtask

  task automatic t_saturate();
    gate = 1'b1;
    step();
    repeat (5) step();
    chk(rej_count, 6, "R7", "count after five");
    repeat (5) step();
    gate = 1'b0;
    chk(rej_count, 7, "R7", "saturated");
    chk(busy, 1, "R1", "busy during readout");
    chk(rd_sel, 0, "R7", "held gate fills once");
    pulse_rd();
    chk(busy, 0, "R8", "busy drop");
    step();
    chk(xfer_sel, 0, "R4", "send 0");
    pulse_tx();
    chk(busy, 0, "R8", "idle at end");
  endtask

  initial begin
    #(4 * 20000);
    if (!fin) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; gate = 1'b0; rdout_done = 1'b0; xfer_done = 1'b0;
    repeat (4) step();
    t_reset();
    rst_n = 1'b1;
    step();
    t_reset();
    t_single();
    t_overlap();
    t_stray();
    t_saturate();
    fin = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule